// File: doc/BRIEF.md
# Fixed-Frame Word Serializer/Deserializer

This block moves a parallel word across a one-bit serial line in frames of constant length. Each frame is two word-boundary marker bits followed by the data bits. The transmit side turns the parallel word into this frame. The receive side finds the frame boundaries in the incoming bit stream and recovers the word. The block works in one direction at a time, and a direction input from an external controller picks which side runs.

A two-bit mode input sets how the top four bits of the word, the control field, are used:

| Mode | Meaning |
|------|---------|
| 0 | Power-down |
| 1 | The control field is received only |
| 2 | The control field is transmitted only |
| 3 | The lower two control bits are transmitted, and the upper two are received |

Bits that are not valid for the current mode go out as zeros, so the frame length never changes. Clock recovery and any line coding other than the boundary marker are handled outside the block.

Top module: `frame_serdes`

## Requirements
- R1: While serializing (`dir_ser`=1, mode not 0), `ser_out` sends frames of DATA_W+2 bits back to back, one bit per clock. Each frame is a 1, then a 0, then data bit 0 through data bit DATA_W-1 (least significant bit first). The first frame starts one clock after the transmitter becomes enabled.
- R2: A `tx_load` pulse stores `tx_word`. A frame carries the word stored most recently by the clock edge that starts that frame. Loads made during a frame do not change that frame. With no new load, the last stored word is sent again.
- R3: Transmit masking. In mode 1 the control field (bits DATA_W-4 to DATA_W-1; bits 20 to 23 at the default width) is sent as 0. In mode 3 bits DATA_W-2 and DATA_W-1 are sent as 0. In mode 2 every bit is sent as stored.
- R4: While deserializing, `rx_valid` is high for exactly one cycle. That cycle follows the clock edge that samples the last bit of a frame whose marker bits are 1 then 0, and it occurs only when the frame before was also correctly framed.
- R5: While hunting for framing, the first correctly marked frame sets up alignment but is not reported. The second consecutive good frame raises `rx_valid`, and `rx_locked` stays high from then on.
- R6: A frame whose marker bits, at the expected position, are not 1 then 0 clears `rx_locked` and is not reported. The next good frame is not reported either. Reporting resumes with the second good frame.
- R7: Receive mapping. In mode 1 `rx_word` equals all received data bits. In mode 2 the control field of `rx_word` is 0. In mode 3 received bit DATA_W-4 appears on output bit DATA_W-2, received bit DATA_W-3 appears on output bit DATA_W-1, and output bits DATA_W-4 and DATA_W-3 are 0.
- R8: `rx_word` changes only in a cycle in which `rx_valid` is high. It keeps its value while the block is serializing and after it turns back, until a new word is reported.
- R9: Power-down (mode 0) or `rst_n` low clears all state on the next clock edge: `ser_out`, `rx_word`, `rx_valid` and `rx_locked` become 0, and the stored transmit word becomes 0.
- R10: With `dir_ser`=0 the transmitter holds `ser_out` at 0. When it is enabled again it starts a fresh frame. With `dir_ser`=1 the receiver reports nothing and drops its lock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Operating mode 0..3 |
| dir_ser | input | 1 | 1 = serialize, 0 = deserialize |
| tx_word | input | DATA_W | Word to transmit |
| tx_load | input | 1 | Stores `tx_word` |
| ser_out | output | 1 | Serial transmit bit |
| ser_in | input | 1 | Serial receive bit |
| rx_word | output | DATA_W | Recovered, mode-mapped word |
| rx_valid | output | 1 | One-cycle new-word pulse |
| rx_locked | output | 1 | Receive framing established |

## Verification
The bench builds the block with DATA_W=8, which gives 10-bit frames and puts the control field in bits 4 to 7. At this width every one of the 256 word values is sent and received in each of the three working modes. This covers every combination of masked and remapped control bits, and every marker-like pattern inside the data. The short frame also keeps the scripted sequences short: framing loss, reacquisition, a turn-around in mid-stream and power-down clearing each take only a few frames.

// File: rtl/frame_serdes_pkg.sv
// Shared definitions for the frame serializer/deserializer.
// Assumes the marker is two bits, sent bit 0 first.
package frame_serdes_pkg;
    typedef enum logic [1:0] {
        MODE_OFF      = 2'd0,
        MODE_CTRL_OUT = 2'd1,
        MODE_CTRL_IN  = 2'd2,
        MODE_SPLIT    = 2'd3
    } serdes_mode_e;

    localparam int unsigned MARK_W = 2;
    // Bit 0 goes out first as 1, then bit 1 as 0.
    localparam logic [MARK_W-1:0] MARK_BITS = 2'b01;
endpackage

// File: rtl/frame_serdes_tx.sv
// Transmit half: builds a marker+data frame and shifts it out LSB first.
// Assumes DATA_W >= 4; words are latched only at frame starts.
module frame_serdes_tx
    import frame_serdes_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  serdes_mode_e      mode,
    input  logic              dir_ser,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              tx_load,
    output logic              ser_out
);
    localparam int FRAME_W = DATA_W + MARK_W;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam int CTRL_LO = DATA_W - 4;
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_W - 1);

    logic [DATA_W-1:0]  hold;
    logic [DATA_W-1:0]  hold_next;
    logic [FRAME_W-1:0] cur;
    logic [CNT_W-1:0]   pos;
    logic               run;
    logic               active;
    logic               frame_end;

    // Zero the bits that are not transmit inputs in this mode.
    function automatic logic [DATA_W-1:0] mask_tx(serdes_mode_e m, logic [DATA_W-1:0] w);
        logic [DATA_W-1:0] r;
        r = w;
        case (m)
            MODE_CTRL_OUT: r[DATA_W-1:CTRL_LO] = '0;
            MODE_SPLIT:    r[DATA_W-1:DATA_W-2] = '0;
            default:       ;
        endcase
        return r;
    endfunction

    assign active    = (mode != MODE_OFF) && dir_ser;
    assign hold_next = tx_load ? tx_word : hold;
    assign frame_end = run && (pos == LAST_POS);
    assign ser_out   = run & cur[0];

    // Store the most recently loaded word.
    always_ff @(posedge clk) begin
        if (!rst_n || mode == MODE_OFF) hold <= '0;
        else if (tx_load)               hold <= tx_word;
    end

    // Start a frame, or shift the current one out one bit per clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            run <= 1'b0;
            pos <= '0;
            cur <= '0;
        end else if (!run || frame_end) begin
            run <= 1'b1;
            pos <= '0;
            cur <= {mask_tx(mode, hold_next), MARK_BITS};
        end else begin
            pos <= pos + CNT_W'(1);
            cur <= {1'b0, cur[FRAME_W-1:1]};
        end
    end

    assert_head_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pos == '0) |-> ser_out);
    assert_head_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pos == CNT_W'(1)) |-> !ser_out);
    assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !ser_out);
    assert_hold_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |=> (hold == '0));
endmodule

// File: rtl/frame_serdes_rx.sv
// Receive half: hunts for the marker and tracks frame alignment.
// It reports a mapped word once two consecutive frames are well framed.
// Assumes ser_in is already aligned to clk.
module frame_serdes_rx
    import frame_serdes_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  serdes_mode_e      mode,
    input  logic              dir_ser,
    input  logic              ser_in,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              rx_locked
);
    localparam int FRAME_W = DATA_W + MARK_W;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam int CTRL_LO = DATA_W - 4;
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] sr;
    logic [FRAME_W-1:0] win;
    logic [CNT_W-1:0]   cnt;
    logic               track;
    logic [1:0]         good;
    logic               active;
    logic               bnd_ok;
    logic               at_end;
    logic               capture;

    // Map received data to the parallel outputs for the given mode.
    function automatic logic [DATA_W-1:0] map_rx(serdes_mode_e m, logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] r;
        r = d;
        case (m)
            MODE_CTRL_IN: r[DATA_W-1:CTRL_LO] = '0;
            MODE_SPLIT: begin
                r[DATA_W-1]          = d[CTRL_LO+1];
                r[DATA_W-2]          = d[CTRL_LO];
                r[CTRL_LO+1:CTRL_LO] = '0;
            end
            default: ;
        endcase
        return r;
    endfunction

    assign active    = (mode != MODE_OFF) && !dir_ser;
    assign win       = {ser_in, sr[FRAME_W-1:1]};
    assign bnd_ok    = (win[MARK_W-1:0] == MARK_BITS);
    assign at_end    = track && (cnt == LAST_POS);
    assign capture   = active && at_end && bnd_ok && (good != 2'd0);
    assign rx_locked = (good == 2'd2);

    // Shift the line in and keep or lose frame alignment.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            sr    <= '0;
            cnt   <= '0;
            track <= 1'b0;
            good  <= 2'd0;
        end else begin
            sr <= win;
            if (!track) begin
                if (bnd_ok) begin
                    track <= 1'b1;
                    cnt   <= '0;
                    good  <= 2'd1;
                end
            end else if (at_end) begin
                cnt <= '0;
                if (bnd_ok) begin
                    good <= 2'd2;
                end else begin
                    track <= 1'b0;
                    good  <= 2'd0;
                end
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // One-cycle strobe for each reported word.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) rx_valid <= 1'b0;
        else                   rx_valid <= capture;
    end

    // Output word register; it holds between reports.
    always_ff @(posedge clk) begin
        if (!rst_n || mode == MODE_OFF) rx_word <= '0;
        else if (capture)               rx_word <= map_rx(mode, win[FRAME_W-1:MARK_W]);
    end

    assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    assert_valid_needs_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> rx_locked);
    assert_word_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_OFF) |=> (rx_valid || $stable(rx_word)));
    assert_ctrl_in_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && $past(mode) == MODE_CTRL_IN) |-> (rx_word[DATA_W-1:CTRL_LO] == '0));
    assert_split_low_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && $past(mode) == MODE_SPLIT) |-> (rx_word[CTRL_LO+1:CTRL_LO] == '0));
    assert_off_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |=> (!rx_valid && !rx_locked && rx_word == '0));
    assert_rx_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dir_ser |=> !rx_valid);
endmodule

// File: rtl/frame_serdes.sv
// Top level: one direction-selected serializer/deserializer that shares
// the mode control. Assumes mode and dir_ser come from a synchronous
// controller.
module frame_serdes
    import frame_serdes_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              dir_ser,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              tx_load,
    output logic              ser_out,
    input  logic              ser_in,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_valid,
    output logic              rx_locked
);
    serdes_mode_e mode_e;

    assign mode_e = serdes_mode_e'(mode);

    frame_serdes_tx #(.DATA_W(DATA_W)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_e),
        .dir_ser (dir_ser),
        .tx_word (tx_word),
        .tx_load (tx_load),
        .ser_out (ser_out)
    );

    frame_serdes_rx #(.DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_e),
        .dir_ser   (dir_ser),
        .ser_in    (ser_in),
        .rx_word   (rx_word),
        .rx_valid  (rx_valid),
        .rx_locked (rx_locked)
    );
endmodule

// File: tb/frame_serdes_tb.sv
`timescale 1ns/1ps
module frame_serdes_tb;
    localparam int DW = 8;
    localparam int FW = DW + 2;
    localparam int NW = 1 << DW;

    logic          clk;
    logic          rst_n;
    logic [1:0]    mode;
    logic          dir_ser;
    logic [DW-1:0] tx_word;
    logic          tx_load;
    logic          ser_out;
    logic          ser_in;
    logic [DW-1:0] rx_word;
    logic          rx_valid;
    logic          rx_locked;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    bit pend_on = 0;
    bit pend_v  = 0;
    logic [DW-1:0] pend_w = '0;
    logic [DW-1:0] last_w = '0;
    logic [FW-1:0] got;

    frame_serdes #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .dir_ser(dir_ser),
        .tx_word(tx_word), .tx_load(tx_load), .ser_out(ser_out),
        .ser_in(ser_in), .rx_word(rx_word), .rx_valid(rx_valid),
        .rx_locked(rx_locked)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    function automatic logic [DW-1:0] low_mask(int keep);
        return DW'((1 << keep) - 1);
    endfunction

    function automatic logic [DW-1:0] exp_tx(int m, logic [DW-1:0] w);
        if (m == 1) return w & low_mask(DW - 4);
        if (m == 3) return w & low_mask(DW - 2);
        return w;
    endfunction

    function automatic logic [DW-1:0] exp_rx(int m, logic [DW-1:0] w);
        if (m == 2) return w & low_mask(DW - 4);
        if (m == 3) return (w & low_mask(DW - 4)) |
                           DW'(((int'(w) >> (DW - 4)) & 3) << (DW - 2));
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rx_pending_check();
        if (pend_on) begin
            chk(rx_valid == pend_v, "R4 word-valid", int'(rx_valid), int'(pend_v));
            chk(rx_locked == pend_v, "R5 R6 lock state", int'(rx_locked), int'(pend_v));
            if (pend_v) begin
                chk(rx_word == pend_w, "R7 mapped word", int'(rx_word), int'(pend_w));
                last_w = pend_w;
            end else begin
                chk(rx_word == last_w, "R8 word held", int'(rx_word), int'(last_w));
            end
        end
        pend_on = 0;
    endtask

    task automatic send_frame(input logic [1:0] mark, input logic [DW-1:0] d,
                              input bit v, input logic [DW-1:0] w);
        logic [FW-1:0] f;
        f = {d, mark};
        for (int j = 0; j < FW; j++) begin
            @(negedge clk);
            if (j == 0) rx_pending_check();
            ser_in = f[j];
        end
        pend_on = 1;
        pend_v  = v;
        pend_w  = w;
    endtask

    task automatic idle(input int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            if (j == 0) rx_pending_check();
            ser_in = 1'b0;
        end
    endtask

    task automatic tx_frame(input bit ld, input logic [DW-1:0] nxt, output logic [FW-1:0] cap);
        for (int j = 0; j < FW; j++) begin
            @(negedge clk);
            cap[j] = ser_out;
            if (j == 0) tx_load = 1'b0;
            if (ld && j == 5) begin
                tx_load = 1'b1;
                tx_word = nxt;
            end
            if (j == 6) tx_load = 1'b0;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [FW-1:0] ef;
        rst_n = 1'b0; mode = 2'd0; dir_ser = 1'b0;
        tx_word = '0; tx_load = 1'b0; ser_in = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(ser_out == 1'b0, "R9 reset ser_out", int'(ser_out), 0);
        chk(rx_valid == 1'b0 && rx_locked == 1'b0, "R9 reset flags",
            int'({rx_valid, rx_locked}), 0);
        chk(rx_word == '0, "R9 reset rx_word", int'(rx_word), 0);
        rst_n = 1'b1;

        // R1 R3: every word in every working mode, back-to-back frames
        for (int m = 1; m < 4; m++) begin
            @(negedge clk); dir_ser = 1'b0; mode = 2'(m);
            @(negedge clk); dir_ser = 1'b1; tx_load = 1'b1; tx_word = '0;
            for (int w = 0; w < NW; w++) begin
                tx_frame(w < NW - 1, DW'(w + 1), got);
                ef = {exp_tx(m, DW'(w)), 2'b01};
                chk(got == ef, "R1 R3 transmitted frame", int'(got), int'(ef));
            end
            @(negedge clk); dir_ser = 1'b0; tx_load = 1'b0;
            @(negedge clk);
            chk(ser_out == 1'b0, "R10 transmitter idle", int'(ser_out), 0);
        end

        // R2: loads in mid-frame apply at the next frame, and the latest one wins
        @(negedge clk); mode = 2'd2;
        @(negedge clk); dir_ser = 1'b1; tx_load = 1'b1; tx_word = 8'hA5;
        for (int j = 0; j < FW; j++) begin
            @(negedge clk);
            got[j] = ser_out;
            tx_load = 1'b0;
            if (j == 2) begin tx_load = 1'b1; tx_word = 8'h3C; end
            if (j == 7) begin tx_load = 1'b1; tx_word = 8'hC3; end
        end
        chk(got == {8'hA5, 2'b01}, "R2 current frame kept", int'(got), int'({8'hA5, 2'b01}));
        tx_frame(0, '0, got);
        chk(got == {8'hC3, 2'b01}, "R2 latest load used", int'(got), int'({8'hC3, 2'b01}));
        tx_frame(0, '0, got);
        chk(got == {8'hC3, 2'b01}, "R2 word repeated", int'(got), int'({8'hC3, 2'b01}));

        // R10: transmitter restarts with a fresh frame
        @(negedge clk); dir_ser = 1'b0;
        repeat (3) @(negedge clk);
        chk(ser_out == 1'b0, "R10 deserialize quiet", int'(ser_out), 0);
        dir_ser = 1'b1;
        tx_frame(0, '0, got);
        chk(got == {8'hC3, 2'b01}, "R10 restart frame", int'(got), int'({8'hC3, 2'b01}));

        // R9: power-down clears the stored transmit word
        @(negedge clk); mode = 2'd0;
        @(negedge clk);
        chk(ser_out == 1'b0, "R9 power-down ser_out", int'(ser_out), 0);
        mode = 2'd2;
        tx_frame(0, '0, got);
        chk(got == {8'h00, 2'b01}, "R9 stored word cleared", int'(got), int'({8'h00, 2'b01}));
        @(negedge clk); dir_ser = 1'b0;

        // R4 R5 R7: exhaustive receive sweep per mode
        for (int m = 1; m < 4; m++) begin
            @(negedge clk); mode = 2'(m);
            idle(FW + 4);
            for (int w = 0; w < NW; w++)
                send_frame(2'b01, DW'(w), w != 0, exp_rx(m, DW'(w)));
            idle(FW + 4);
        end

        // R6: bad marker drops lock; two good frames needed to resume
        @(negedge clk); mode = 2'd1;
        idle(FW + 4);
        send_frame(2'b01, 8'h5A, 0, '0);
        send_frame(2'b01, 8'h96, 1, 8'h96);
        send_frame(2'b00, 8'h00, 0, '0);
        send_frame(2'b01, 8'h71, 0, '0);
        send_frame(2'b01, 8'hE4, 1, 8'hE4);
        idle(FW + 4);

        // R8 R10: the word is held across a turn-around; the receiver is idle while serializing
        @(negedge clk); dir_ser = 1'b1;
        send_frame(2'b01, 8'h11, 0, '0);
        send_frame(2'b01, 8'h22, 0, '0);
        idle(2);
        @(negedge clk); dir_ser = 1'b0;
        idle(FW + 4);
        send_frame(2'b01, 8'h33, 0, '0);
        send_frame(2'b01, 8'h44, 1, 8'h44);
        idle(FW + 4);

        // R9: power-down clears the receive side
        @(negedge clk); mode = 2'd0;
        @(negedge clk);
        chk(rx_word == '0, "R9 power-down rx_word", int'(rx_word), 0);
        chk(rx_locked == 1'b0 && rx_valid == 1'b0, "R9 power-down flags",
            int'({rx_locked, rx_valid}), 0);
        mode = 2'd1;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule